// File: doc/BRIEF.md
# Programmable Time Base Interrupt Timer

This block is a periodic timer. It counts oscillator clock cycles and marks the end of each programmed period with an overflow event. Software picks one of four period lengths through a 2-bit select field. The block holds an overflow flag and an interrupt enable in one control and status byte, which is reached through a simple write and read port. It drives a level interrupt request and a wake-up request.

A new period selection is held as pending and is loaded only when the running period ends. Because of this, the timer can serve as a real-time base with no phase jump when its rate is changed. With the default parameters the four periods are 16000, 32000, 80000 and 200000 cycles. That is 4, 8, 20 and 50 ms at 4 MHz, and 2, 4, 10 and 25 ms at 8 MHz.

Two mode inputs control power behaviour:
- A full halt freezes the counter and every register. The timer cannot raise a wake-up during a full halt.
- The active-halt indication keeps the timer running, so that its overflow can wake the device. Active-halt takes priority over halt.
- In normal operation, including wait mode, the wake-up request follows the interrupt request.

Top module: `tbase_timer`

## Requirements
- R1: After reset the status byte reads 00h: select field 00, interrupt disabled, flag clear. The `irq` and `wake_req` outputs are low.
- R2: While running, with select code s in bits [1:0], an overflow happens every PERs clock cycles (00→PER0, 01→PER1, 10→PER2, 11→PER3). The counter restarts from zero at reset and at each overflow.
- R3: A write to the select field is read back at once in bits [1:0]. The period already in progress still completes with its old length, and the new length starts with the next period.
- R4: Each overflow sets the flag in bit 7. A read (`rd_en`) while running clears the flag. If a read and an overflow fall on the same edge, the flag is set.
- R5: Write data in bit 7 has no effect on the flag. Bits 6:3 always read 0.
- R6: Bit 2 is the interrupt enable. `irq` is high exactly while the flag and the enable are both 1. Changing the enable does not alter the flag.
- R7: With `halt`=1 and `active_halt`=0, the following are frozen: the counter, the status byte, writes and reads. `wake_req` is low. Once halt is released, counting resumes from the frozen count.
- R8: With `active_halt`=1, counting continues whatever the state of `halt`, and `wake_req` rises with `irq`.
- R9: Whenever the block is not frozen, `wake_req` equals `irq`. This is the signal that ends wait mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the status byte |
| rd_en | input | 1 | Read strobe; clears the flag |
| wdata | input | 8 | Write data: [1:0] select, [2] enable |
| halt | input | 1 | Full halt mode |
| active_halt | input | 1 | Active-halt mode; timer keeps running |
| rdata | output | 8 | {flag, 0000, enable, select} |
| irq | output | 1 | Level interrupt request |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench runs small periods and walks through all sixteen old-to-new select transitions. A design that loads the new select straight away would give the wrong length for the period that was already in progress.

It places a read on exactly the overflow edge. If clear had priority over set there, that overflow would be lost.

It halts with the counter part-way through a period and tries a write and a read during the halt. A design that let the counter run on, or reset it, would show a shifted next overflow after release. One that accepted the access would show a changed status byte.

Active-halt is exercised both with and without `halt`. A timer frozen by `halt` in that case would never wake the device.

// File: rtl/tbase_timer.sv
module tbase_timer #(
  parameter int unsigned PER0 = 16000,
  parameter int unsigned PER1 = 32000,
  parameter int unsigned PER2 = 80000,
  parameter int unsigned PER3 = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  input  logic       halt,
  input  logic       active_halt,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       wake_req
);
  localparam int unsigned PMAX01 = (PER0 > PER1) ? PER0 : PER1;
  localparam int unsigned PMAX23 = (PER2 > PER3) ? PER2 : PER3;
  localparam int unsigned PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
  localparam int unsigned CNT_W  = $clog2(PMAX);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       cur_sel;
  logic [1:0]       sel_q;
  logic             ie_q;
  logic             flag_q;
  logic             run;
  logic             wrap;
  logic [CNT_W-1:0] last;

  always_comb begin
    case (cur_sel)
      2'd0:    last = CNT_W'(PER0 - 1);
      2'd1:    last = CNT_W'(PER1 - 1);
      2'd2:    last = CNT_W'(PER2 - 1);
      default: last = CNT_W'(PER3 - 1);
    endcase
  end

  assign run  = active_halt | ~halt;
  assign wrap = run & (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_sel <= 2'd0;
      sel_q   <= 2'd0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else if (run) begin
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
      if (wrap)
        cur_sel <= sel_q;
      if (wr_en) begin
        sel_q <= wdata[1:0];
        ie_q  <= wdata[2];
      end
      if (wrap)
        flag_q <= 1'b1;
      else if (rd_en)
        flag_q <= 1'b0;
    end
  end

  assign rdata    = {flag_q, 4'b0000, ie_q, sel_q};
  assign irq      = flag_q & ie_q;
  assign wake_req = irq & run;
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
  parameter int unsigned PER0 = 16000,
  parameter int unsigned PER1 = 32000,
  parameter int unsigned PER2 = 80000,
  parameter int unsigned PER3 = 200000,
  parameter int unsigned CNT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             halt,
  input logic             active_halt,
  input logic [7:0]       rdata,
  input logic             irq,
  input logic             wake_req,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       cur_sel
);
  logic [CNT_W-1:0] lim;
  logic             frz;

  always_comb begin
    case (cur_sel)
      2'd0:    lim = CNT_W'(PER0 - 1);
      2'd1:    lim = CNT_W'(PER1 - 1);
      2'd2:    lim = CNT_W'(PER2 - 1);
      default: lim = CNT_W'(PER3 - 1);
    endcase
  end

  assign frz = halt && !active_halt;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= lim); // R2
  AST_SEL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) (cur_sel != $past(cur_sel)) |-> (cnt == '0)); // R3
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (!frz && cnt == lim) |=> rdata[7]); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (!frz && rd_en && cnt != lim) |=> !rdata[7]); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rdata[6:3] == 4'b0000); // R5
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n) !rdata[2] |-> !irq); // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) frz |=> ($stable(cnt) && $stable(rdata))); // R7
  AST_HALT_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n) frz |-> !wake_req); // R7
  AST_ACTIVE_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (active_halt && irq) |-> wake_req); // R8
  AST_RUN_WAKE: assert property (@(posedge clk) disable iff (!rst_n) !frz |-> (wake_req == irq)); // R9
endmodule

bind tbase_timer tbase_timer_chk #(
  .PER0(PER0), .PER1(PER1), .PER2(PER2), .PER3(PER3), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .halt(halt), .active_halt(active_halt),
  .rdata(rdata), .irq(irq), .wake_req(wake_req), .cnt(cnt), .cur_sel(cur_sel)
);

// File: tb/sim_tbase_timer.sv
module sim_tbase_timer;
  localparam int P0 = 4, P1 = 6, P2 = 9, P3 = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       halt = 1'b0;
  logic       active_halt = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  logic       wake_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tbase_timer #(.PER0(P0), .PER1(P1), .PER2(P2), .PER3(P3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .halt(halt), .active_halt(active_halt), .rdata(rdata), .irq(irq), .wake_req(wake_req)
  );

  function automatic int per(input int s);
    case (s)
      0: return P0;
      1: return P1;
      2: return P2;
      default: return P3;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    edge1();
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] v);
    wr_en = 1'b1;
    wdata = v;
    edge1();
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    while (!rdata[7] && n < 1000) begin
      edge1();
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int cur;
    int seq [17] = '{0, 0, 1, 0, 2, 0, 3, 1, 1, 2, 1, 3, 2, 2, 3, 3, 0};

    @(negedge clk);
    repeat (3) edge1();
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake_req, 0);
    rst_n = 1'b1;

    wait_flag(n);
    chk("R2 first period", n, P0);
    chk("R6 irq disabled", irq, 0);

    cur = 0;
    for (int i = 1; i < 17; i++) begin
      do_read();
      chk("R4 read clear", rdata[7], 0);
      do_write({5'b00000, 1'b1, 2'(seq[i])});
      chk("R3 readback", rdata[1:0], seq[i]);
      wait_flag(n);
      chk("R3 old period kept", n + 2, per(cur));
      chk("R6 irq", irq, 1);
      chk("R9 wake", wake_req, 1);
      cur = seq[i];
    end

    do_read();
    repeat (P0 - 2) edge1();
    chk("R4 before wrap", rdata[7], 0);
    do_read();
    chk("R4 set wins", rdata[7], 1);

    do_read();
    do_write(8'hFC);
    chk("R5 rdata", rdata, 8'h04);

    wait_flag(n);
    chk("R2 P0 after R5", n + 2, P0);
    chk("R6 irq on", irq, 1);
    do_write(8'h00);
    chk("R6 irq off", irq, 0);
    chk("R6 flag kept", rdata[7], 1);
    chk("R9 wake off", wake_req, 0);
    do_write(8'h04);
    chk("R6 irq back", irq, 1);

    halt = 1'b1;
    edge1();
    chk("R7 no wake", wake_req, 0);
    do_write(8'h03);
    do_read();
    repeat (40) edge1();
    chk("R7 rdata frozen", rdata, 8'h84);
    chk("R7 no wake late", wake_req, 0);
    halt = 1'b0;
    #1;
    chk("R9 wake after halt", wake_req, 1);
    do_read();
    chk("R4 clear after halt", rdata[7], 0);
    wait_flag(n);
    chk("R7 resume count", n, P0 - 3);

    do_read();
    halt = 1'b1;
    active_halt = 1'b1;
    wait_flag(n);
    chk("R8 runs in active halt", n, P0 - 1);
    chk("R8 wake", wake_req, 1);
    halt = 1'b0;
    do_read();
    wait_flag(n);
    chk("R8 active only", n, P0 - 1);
    chk("R8 wake active only", wake_req, 1);
    active_halt = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule